// File: doc/BRIEF.md
# Ferroelectric RAM Identification Probe Sequencer

This block runs once after reset. It uses a plain byte-transfer SPI port to find out whether a ferroelectric RAM device is present and what size it is. It opens one chip-select frame per command. The first frame reads the status byte and gives up if the device reports that it is busy. The second frame reads the nine-byte identification block. From that block the sequencer checks the maker code, turns the size code into a power-of-two byte capacity, and picks two or three address bytes. If the identification block says that a serial number exists, a third frame fetches eight serial bytes and stores them in reversed byte order.

The results are a done flag, a pass flag, a two-bit error code, the capacity in bytes, the address-byte count and the serial number. All of them stay frozen until the next reset. The byte port works as a request/response pair. The sequencer raises `xfer_req` for one cycle with the byte to send. The port later pulses `xfer_done` for one cycle with the byte it received. The sequencer never issues a new request while one is outstanding.

Top module: `fram_probe_seq`

## Requirements
- R1: The first frame carries opcode 0x05 followed by one data byte. If bit 0 of that status byte is 1, the probe ends with `probe_err` = 1 (busy) and no further frame is opened. Other status bits have no effect.
- R2: After a status byte with bit 0 at 0, a second frame carries opcode 0x9F followed by exactly 9 data bytes. These are numbered 0 to 8 in the order received.
- R3: If identification byte 6 is not 0xC2, the probe ends with `probe_err` = 2. Capacity, address bytes, serial and `has_serial` are then all zero.
- R4: If byte 6 is correct but identification byte 7 lies outside 0x21..0x26, the probe ends with `probe_err` = 3. The outputs are zeroed as in R3.
- R5: On success, `capacity` equals 2^(byte7 − 0x21 + 14) bytes, which ranges from 16 KiB to 512 KiB.
- R6: On success, `addr_bytes` is 3 when the capacity is above 65536 bytes and 2 otherwise.
- R7: On success with identification byte 8 nonzero, a third frame carries opcode 0xC3 followed by 8 data bytes. `has_serial` is then 1, and `serial[8k+7:8k]` holds the serial byte received in position 7−k, so the last byte received lands in bits 7:0.
- R8: On success with identification byte 8 equal to zero, no serial frame is opened, `has_serial` is 0 and `serial` is zero.
- R9: Each command has its own frame. `spi_cs_n` is low for the whole frame and goes high between frames. `xfer_req` is only asserted while `spi_cs_n` is low. Bytes sent after an opcode are 0x00.
- R10: After reset, `probe_done`, `probe_ok`, `probe_err`, `xfer_req` are 0 and `spi_cs_n` is 1. `probe_done` rises one cycle after the final decision. From then on, every output holds until reset, `spi_cs_n` stays high, and `probe_ok` is 1 exactly when `probe_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the probe restarts on release |
| spi_cs_n | output | 1 | Active-low chip select, one frame per command |
| xfer_req | output | 1 | One-cycle request to shift a byte |
| xfer_tx | output | 8 | Byte to send with the request |
| xfer_done | input | 1 | One-cycle completion of the outstanding byte |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| probe_done | output | 1 | Probe finished |
| probe_ok | output | 1 | Device identified |
| probe_err | output | 2 | 0 none, 1 busy, 2 wrong maker, 3 unsupported size |
| capacity | output | 20 | Device capacity in bytes |
| addr_bytes | output | 2 | Address bytes per access (2 or 3, 0 on failure) |
| has_serial | output | 1 | Serial number was fetched |
| serial | output | 64 | Serial number, byte-reversed |

## Verification
The path hardest to reach is a full three-frame probe. It needs a quiet status byte, the right maker code, a size code inside the narrow valid window and a nonzero serial flag, all in the same run. Random stimulus alone lands in the error branches most of the time. The directed cases therefore walk every valid size code with the serial flag set and cleared, and use a counting serial pattern so that the byte reversal can be seen. The random cases bias the maker code and size code towards acceptance, with varied transfer latencies. The size window edges 0x20 and 0x27 are applied directly, and so are status bytes that set bits other than bit 0.

// File: rtl/fram_probe_pkg.sv
package fram_probe_pkg;

    typedef enum logic [2:0] {
        S_GAP   = 3'd0,
        S_OP    = 3'd1,
        S_OP_W  = 3'd2,
        S_DAT   = 3'd3,
        S_DAT_W = 3'd4,
        S_END   = 3'd5,
        S_DONE  = 3'd6
    } state_t;

    typedef enum logic [1:0] {
        CMD_STAT = 2'd0,
        CMD_ID   = 2'd1,
        CMD_SN   = 2'd2
    } cmd_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_BUSY  = 2'd1,
        ERR_MAKER = 2'd2,
        ERR_SIZE  = 2'd3
    } err_t;

    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_IDENT  = 8'h9F;
    localparam logic [7:0] OPC_SERIAL = 8'hC3;

endpackage

// File: rtl/fram_id_decode.sv
module fram_id_decode #(
    parameter logic [7:0] MAKER_CODE = 8'hC2,
    parameter logic [7:0] SIZE_MIN   = 8'h21,
    parameter logic [7:0] SIZE_MAX   = 8'h26,
    parameter int         BASE_LOG2  = 14,
    parameter int         WIDE_LOG2  = 16,
    parameter int         CAP_W      = 20
) (
    input  logic [7:0]       maker_byte,
    input  logic [7:0]       size_byte,
    input  logic [7:0]       flag_byte,
    output logic             maker_ok,
    output logic             size_ok,
    output logic [CAP_W-1:0] cap_bytes,
    output logic [1:0]       addr_len,
    output logic             want_serial
);
    logic [7:0] rel_code;

    always_comb begin
        maker_ok    = (maker_byte == MAKER_CODE);
        size_ok     = (size_byte >= SIZE_MIN) && (size_byte <= SIZE_MAX);
        rel_code    = size_byte - SIZE_MIN;
        cap_bytes   = size_ok ? ((CAP_W'(1) << rel_code) << BASE_LOG2) : '0;
        addr_len    = (|(cap_bytes >> (WIDE_LOG2 + 1))) ? 2'd3 : 2'd2;
        want_serial = (flag_byte != 8'h00);
    end
endmodule

// File: rtl/fram_sn_shift.sv
module fram_sn_shift #(
    parameter int SN_LEN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [7:0]          byte_in,
    output logic [SN_LEN*8-1:0] sn_out
);
    logic [7:0] lane_q [SN_LEN];

    for (genvar k = 0; k < SN_LEN; k++) begin : g_lane
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        lane_q[k] <= '0;
                else if (shift_en) lane_q[k] <= byte_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        lane_q[k] <= '0;
                else if (shift_en) lane_q[k] <= lane_q[k-1];
            end
        end
        assign sn_out[8*k +: 8] = lane_q[k];
    end
endmodule

// File: rtl/fram_probe_seq.sv
module fram_probe_seq
    import fram_probe_pkg::*;
#(
    parameter int         ID_LEN     = 9,
    parameter int         SN_LEN     = 8,
    parameter logic [7:0] MAKER_CODE = 8'hC2,
    parameter logic [7:0] SIZE_MIN   = 8'h21,
    parameter logic [7:0] SIZE_MAX   = 8'h26,
    parameter int         BASE_LOG2  = 14,
    parameter int         WIDE_LOG2  = 16,
    localparam int        CAP_W      = BASE_LOG2 + int'(SIZE_MAX - SIZE_MIN) + 1,
    localparam int        SN_W       = SN_LEN * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             spi_cs_n,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx,
    output logic             probe_done,
    output logic             probe_ok,
    output logic [1:0]       probe_err,
    output logic [CAP_W-1:0] capacity,
    output logic [1:0]       addr_bytes,
    output logic             has_serial,
    output logic [SN_W-1:0]  serial
);
    localparam int MAX_LEN = (ID_LEN > SN_LEN) ? ID_LEN : SN_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        state_t           state;
        cmd_t             cmd;
        logic [CNT_W-1:0] cnt;
        logic [23:0]      win;
        logic             done;
        logic             ok;
        err_t             err;
        logic [CAP_W-1:0] cap;
        logic [1:0]       addr;
        logic             has_sn;
    } regs_t;

    regs_t q, d;

    logic             dec_maker_ok, dec_size_ok, dec_want_sn;
    logic [CAP_W-1:0] dec_cap;
    logic [1:0]       dec_addr;
    logic [CNT_W-1:0] frame_len;
    logic             sn_shift;

    fram_id_decode #(
        .MAKER_CODE(MAKER_CODE), .SIZE_MIN(SIZE_MIN), .SIZE_MAX(SIZE_MAX),
        .BASE_LOG2(BASE_LOG2), .WIDE_LOG2(WIDE_LOG2), .CAP_W(CAP_W)
    ) dec_i (
        .maker_byte (q.win[23:16]),
        .size_byte  (q.win[15:8]),
        .flag_byte  (q.win[7:0]),
        .maker_ok   (dec_maker_ok),
        .size_ok    (dec_size_ok),
        .cap_bytes  (dec_cap),
        .addr_len   (dec_addr),
        .want_serial(dec_want_sn)
    );

    assign sn_shift = (q.state == S_DAT_W) && xfer_done && (q.cmd == CMD_SN);

    fram_sn_shift #(.SN_LEN(SN_LEN)) sn_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(sn_shift),
        .byte_in (xfer_rx),
        .sn_out  (serial)
    );

    always_comb begin
        case (q.cmd)
            CMD_STAT: frame_len = CNT_W'(1);
            CMD_ID:   frame_len = CNT_W'(ID_LEN);
            default:  frame_len = CNT_W'(SN_LEN);
        endcase
    end

    always_comb begin
        d = q;
        case (q.state)
            S_GAP:  d.state = S_OP;
            S_OP:   d.state = S_OP_W;
            S_OP_W: begin
                if (xfer_done) begin
                    d.state = S_DAT;
                    d.cnt   = '0;
                end
            end
            S_DAT:  d.state = S_DAT_W;
            S_DAT_W: begin
                if (xfer_done) begin
                    d.win = {q.win[15:0], xfer_rx};
                    d.cnt = q.cnt + CNT_W'(1);
                    d.state = (q.cnt + CNT_W'(1) == frame_len) ? S_END : S_DAT;
                end
            end
            S_END: begin
                case (q.cmd)
                    CMD_STAT: begin
                        if (q.win[0]) begin
                            d.err   = ERR_BUSY;
                            d.state = S_DONE;
                        end else begin
                            d.cmd   = CMD_ID;
                            d.state = S_GAP;
                        end
                    end
                    CMD_ID: begin
                        if (!dec_maker_ok) begin
                            d.err   = ERR_MAKER;
                            d.state = S_DONE;
                        end else if (!dec_size_ok) begin
                            d.err   = ERR_SIZE;
                            d.state = S_DONE;
                        end else begin
                            d.cap  = dec_cap;
                            d.addr = dec_addr;
                            if (dec_want_sn) begin
                                d.cmd   = CMD_SN;
                                d.state = S_GAP;
                            end else begin
                                d.ok    = 1'b1;
                                d.state = S_DONE;
                            end
                        end
                    end
                    default: begin
                        d.ok     = 1'b1;
                        d.has_sn = 1'b1;
                        d.state  = S_DONE;
                    end
                endcase
            end
            default: d.done = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= regs_t'('0);
        else        q <= d;
    end

    always_comb begin
        spi_cs_n = !((q.state == S_OP) || (q.state == S_OP_W) ||
                     (q.state == S_DAT) || (q.state == S_DAT_W));
        xfer_req = (q.state == S_OP) || (q.state == S_DAT);
        xfer_tx  = 8'h00;
        if (q.state == S_OP) begin
            case (q.cmd)
                CMD_STAT: xfer_tx = OPC_STATUS;
                CMD_ID:   xfer_tx = OPC_IDENT;
                default:  xfer_tx = OPC_SERIAL;
            endcase
        end
    end

    assign probe_done = q.done;
    assign probe_ok   = q.ok;
    assign probe_err  = q.err;
    assign capacity   = q.cap;
    assign addr_bytes = q.addr;
    assign has_serial = q.has_sn;
endmodule

// File: rtl/fram_probe_chk.sv
module fram_probe_chk #(
    parameter int CAP_W     = 20,
    parameter int SN_W      = 64,
    parameter int WIDE_LOG2 = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs_n,
    input logic             xfer_req,
    input logic             probe_done,
    input logic             probe_ok,
    input logic [1:0]       probe_err,
    input logic [CAP_W-1:0] capacity,
    input logic [1:0]       addr_bytes,
    input logic             has_serial,
    input logic [SN_W-1:0]  serial
);
    AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |-> !spi_cs_n); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) probe_done |=> probe_done && $stable(capacity) && $stable(serial) && $stable(probe_err) && $stable(probe_ok)); // R10
    AST_OK_MATCHES_ERR: assert property (@(posedge clk) disable iff (!rst_n) probe_done |-> (probe_ok == (probe_err == 2'd0))); // R10
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) probe_done |-> spi_cs_n && !xfer_req); // R10
    AST_CAP_POW2: assert property (@(posedge clk) disable iff (!rst_n) (probe_done && probe_ok) |-> ($countones(capacity) == 1)); // R5
    AST_ADDR_RULE: assert property (@(posedge clk) disable iff (!rst_n) (probe_done && probe_ok) |-> (addr_bytes == ((capacity > (CAP_W'(1) << WIDE_LOG2)) ? 2'd3 : 2'd2))); // R6
    AST_NO_SERIAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (probe_done && !has_serial) |-> (serial == '0)); // R8
    AST_FAIL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (probe_done && !probe_ok) |-> (capacity == '0 && addr_bytes == 2'd0 && !has_serial)); // R3
endmodule

bind fram_probe_seq fram_probe_chk #(.CAP_W(CAP_W), .SN_W(SN_W), .WIDE_LOG2(WIDE_LOG2)) chk_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .xfer_req(xfer_req),
    .probe_done(probe_done), .probe_ok(probe_ok), .probe_err(probe_err),
    .capacity(capacity), .addr_bytes(addr_bytes), .has_serial(has_serial),
    .serial(serial)
);

// File: tb/fram_probe_seq_tb.sv
`timescale 1ns/1ps
module fram_probe_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n, xfer_req, xfer_done, probe_done, probe_ok, has_serial;
    logic [7:0]  xfer_tx, xfer_rx;
    logic [1:0]  probe_err, addr_bytes;
    logic [19:0] capacity;
    logic [63:0] serial;

    always #10 clk = ~clk;

    fram_probe_seq dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .xfer_req(xfer_req),
        .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
        .probe_done(probe_done), .probe_ok(probe_ok), .probe_err(probe_err),
        .capacity(capacity), .addr_bytes(addr_bytes), .has_serial(has_serial),
        .serial(serial)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [7:0] t_stat;
    logic [7:0] t_id [9];
    logic [7:0] t_sn [8];
    int nfr, stray, nonzero_pad;
    logic [7:0] fr_op [4];
    int fr_len [4];
    bit prev_cs = 1'b1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] resp(input logic [7:0] op, input int idx);
        if (idx == 0) return 8'hFF;
        case (op)
            8'h05: return t_stat;
            8'h9F: return (idx <= 9) ? t_id[idx-1] : 8'h00;
            8'hC3: return (idx <= 8) ? t_sn[idx-1] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    // byte-port and device model
    initial begin
        xfer_done = 1'b0;
        xfer_rx = 8'h00;
        forever begin
            @(negedge clk);
            xfer_done = 1'b0;
            if (prev_cs && !spi_cs_n) begin
                if (nfr < 4) fr_len[nfr] = 0;
                nfr++;
            end
            prev_cs = spi_cs_n;
            if (xfer_req) begin
                int f;
                int idx;
                logic [7:0] op;
                f = nfr - 1;
                idx = 0;
                op = 8'h00;
                if (spi_cs_n) stray++;
                if (f >= 0 && f < 4) begin
                    idx = fr_len[f];
                    if (idx == 0) fr_op[f] = xfer_tx;
                    else if (xfer_tx != 8'h00) nonzero_pad++;
                    fr_len[f]++;
                    op = fr_op[f];
                end
                repeat (1 + $urandom % 3) @(negedge clk);
                xfer_rx = resp(op, idx);
                xfer_done = 1'b1;
            end
        end
    end

    function automatic int e_err();
        if (t_stat[0]) return 1;
        if (t_id[6] != 8'hC2) return 2;
        if (t_id[7] < 8'h21 || t_id[7] > 8'h26) return 3;
        return 0;
    endfunction

    function automatic longint e_cap();
        if (e_err() != 0) return 0;
        return longint'(1) << (int'(t_id[7]) - 'h21 + 14);
    endfunction

    function automatic int e_addr();
        if (e_err() != 0) return 0;
        return (e_cap() > 65536) ? 3 : 2;
    endfunction

    function automatic bit e_hs();
        return (e_err() == 0) && (t_id[8] != 8'h00);
    endfunction

    function automatic logic [63:0] e_serial();
        logic [63:0] s = '0;
        if (e_hs()) for (int k = 0; k < 8; k++) s[8*k +: 8] = t_sn[7-k];
        return s;
    endfunction

    task automatic run_case(input bit check_reset);
        int e, wait_n;
        @(negedge clk);
        rst_n = 1'b0;
        nfr = 0;
        stray = 0;
        nonzero_pad = 0;
        repeat (3) @(negedge clk);
        if (check_reset) begin
            chk(probe_done == 0 && probe_ok == 0 && probe_err == 0, "R10 reset flags", {probe_done, probe_ok, probe_err}, 0);
            chk(spi_cs_n == 1 && xfer_req == 0, "R10 reset port", {spi_cs_n, xfer_req}, 2);
        end
        rst_n = 1'b1;
        wait_n = 0;
        while (!probe_done && wait_n < 3000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(probe_done == 1, "R10 done", probe_done, 1);
        e = e_err();
        chk(probe_err == e[1:0], "R1 R3 R4 err code", probe_err, e);
        chk(probe_ok == (e == 0), "R10 ok flag", probe_ok, e == 0);
        chk(capacity == e_cap(), "R5 capacity", capacity, e_cap());
        chk(addr_bytes == e_addr(), "R6 addr bytes", addr_bytes, e_addr());
        chk(has_serial == e_hs(), "R7 R8 has_serial", has_serial, e_hs());
        chk(serial == e_serial(), "R7 R8 serial", serial, e_serial());
        chk(nfr == ((e == 1) ? 1 : (e != 0) ? 2 : e_hs() ? 3 : 2), "R9 frame count", nfr, 0);
        chk(stray == 0 && nonzero_pad == 0, "R9 framing", stray * 100 + nonzero_pad, 0);
        chk(fr_op[0] == 8'h05 && fr_len[0] == 2, "R1 status frame", {fr_op[0], 8'(fr_len[0])}, 16'h0502);
        if (e != 1) chk(fr_op[1] == 8'h9F && fr_len[1] == 10, "R2 id frame", {fr_op[1], 8'(fr_len[1])}, 16'h9F0A);
        if (e_hs()) chk(fr_op[2] == 8'hC3 && fr_len[2] == 9, "R7 serial frame", {fr_op[2], 8'(fr_len[2])}, 16'hC309);
        repeat (25) @(negedge clk);
        chk(probe_done && capacity == e_cap() && serial == e_serial() && spi_cs_n, "R10 hold", capacity, e_cap());
        chk(nfr == ((e == 1) ? 1 : (e != 0) ? 2 : e_hs() ? 3 : 2), "R10 no new frame", nfr, 0);
    endtask

    task automatic set_dev(input logic [7:0] st, input logic [7:0] mk, input logic [7:0] sz, input logic [7:0] fl);
        t_stat = st;
        for (int i = 0; i < 6; i++) t_id[i] = 8'(8'h40 + i);
        t_id[6] = mk;
        t_id[7] = sz;
        t_id[8] = fl;
        for (int i = 0; i < 8; i++) t_sn[i] = 8'(i + 1);
    endtask

    initial begin
        void'($urandom(1234));
        set_dev(8'h00, 8'hC2, 8'h21, 8'h00);
        run_case(1);                                // R5 R6 R8 smallest size
        set_dev(8'h01, 8'hC2, 8'h21, 8'h01); run_case(0);  // R1 busy
        set_dev(8'h83, 8'hC2, 8'h22, 8'h01); run_case(0);  // R1 busy with other bits
        set_dev(8'h8E, 8'hC2, 8'h22, 8'h01); run_case(0);  // R1 other bits ignored
        set_dev(8'h00, 8'hC1, 8'h22, 8'h01); run_case(0);  // R3 wrong maker
        set_dev(8'h00, 8'hC2, 8'h20, 8'h01); run_case(0);  // R4 below window
        set_dev(8'h00, 8'hC2, 8'h27, 8'h01); run_case(0);  // R4 above window
        for (int s = 'h21; s <= 'h26; s++) begin
            set_dev(8'h00, 8'hC2, 8'(s), 8'h5A); run_case(0);  // R5 R6 R7
            set_dev(8'h00, 8'hC2, 8'(s), 8'h00); run_case(0);  // R8
        end
        for (int n = 0; n < 40; n++) begin
            t_stat = 8'($urandom) & (($urandom % 8 == 0) ? 8'hFF : 8'hFE);
            for (int i = 0; i < 9; i++) t_id[i] = 8'($urandom);
            if ($urandom % 8 != 0) t_id[6] = 8'hC2;
            t_id[7] = 8'(8'h1F + $urandom % 10);
            if ($urandom % 2 == 0) t_id[8] = 8'h00;
            for (int i = 0; i < 8; i++) t_sn[i] = 8'($urandom);
            run_case(0);
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule